// File: doc/BRIEF.md
# Real-Time Clock Register Port with Interrupt Status

This block is the host-facing side of a real-time clock. Software selects a register by writing an index to the even port, then reads or writes one byte at a time through the odd port. The block holds the control registers at indices 0x0A to 0x0D, a 128-byte general store for every other index, and the interrupt status register. That status register gathers periodic, alarm and update-ended events into sticky flags. It also drives a level-sensitive interrupt line.

A sub-second prescaler advances on a 32.768 kHz tick enable. Once per second it produces the update strobe (`sec_pulse`), which the external time counters use. The prescaler also sets the update-in-progress bit during a fixed window just before that strobe. Periodic and alarm events come in as single-cycle pulses from outside. The prescaler can be held by the divider-control field, and the set-mode bit suppresses updates. When the divider is released, the first update follows half a second later.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even port (bus_addr=0) latches bus_wdata[6:0] as the index. An odd-port access reads or writes the byte at that index. Indices other than 0x0A to 0x0D are plain storage that reads back what was written. An even-port read returns 0xFF.
- R2: After rst, register A (index 0x0A) reads 0x26, B (0x0B) reads 0x02, C (0x0C) reads 0x00, D (0x0D) reads 0x80, and irq is low.
- R3: Writes to C and D have no effect. Bit 7 of A is the read-only update-in-progress bit, and a write to it is ignored.
- R4: A read of C returns its current value. C then becomes 0x00 and irq falls. An event that arrives in the same cycle as the read is kept, not lost.
- R5: C bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Each is enabled by B bit 6, bit 5 and bit 4 respectively. A newly set flag whose enable is 1 sets C bit 7 and raises irq. A flag whose enable is 0 sets only its own bit.
- R6: A write to B raises C bit 7 and irq at once if any enable bit being written matches a pending flag. Otherwise it clears C bit 7 and irq and leaves the flags unchanged.
- R7: A bit 7 reads 1 for the last UIP_TICKS ticks of each second. On the TICKS_PER_SEC-th tick, sec_pulse is high for that cycle and the update flag is set.
- R8: While A[6:5] is 11 (divider held), or while B bit 7 (set mode) is 1, A bit 7 reads 0 and no update occurs.
- R9: When A[6:4] leaves the held value 11x, the first update comes TICKS_PER_SEC/2 ticks later.
- R10: A soft_rst pulse clears B bits 6, 5 and 3 and all of C, and lowers irq. The other bits of B keep their values.
- R11: irq is a level. Once raised, it stays high until C is read, B is written with no matching enable, or a reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | System reset pulse: clears enables and flags |
| bus_addr | input | 1 | Port select: 0 index, 1 data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effects at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| tick_en | input | 1 | 32.768 kHz tick enable |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| sec_pulse | output | 1 | One-second update strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with TICKS_PER_SEC=64 and UIP_TICKS=8, so a full second takes 64 tick cycles. With these values, a run of tests can reach the edges of the update-in-progress window, the wrap point, the half-second restart after a divider hold, and seconds lost under set mode, while keeping the window the same width as at full rate. The storage depth stays at its default of 128, so the index wrap through bit 7 is also checked.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

    localparam logic [6:0] IDX_A = 7'h0A;
    localparam logic [6:0] IDX_B = 7'h0B;
    localparam logic [6:0] IDX_C = 7'h0C;
    localparam logic [6:0] IDX_D = 7'h0D;

    localparam logic [6:0] A_RST = 7'h26;
    localparam logic [7:0] B_RST = 8'h02;
    localparam logic [7:0] D_VAL = 8'h80;

    // enables cleared by a system reset: periodic, alarm, square wave
    localparam logic [7:0] B_SOFT_CLR = 8'h68;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } rtc_evt_t;

    function automatic logic dv_held(input logic [2:0] dv);
        return dv[2:1] == 2'b11;
    endfunction

    function automatic logic dv_running(input logic [2:0] dv);
        return dv <= 3'b010;
    endfunction

    function automatic logic is_ctrl_idx(input logic [6:0] idx);
        return idx >= IDX_A && idx <= IDX_D;
    endfunction

endpackage

// File: rtl/rtc_divchain.sv
module rtc_divchain #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [2:0] dv,
    input  logic       halt,
    output logic       uip,
    output logic       sec_pulse
);
    import rtc_regport_pkg::*;

    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
    localparam logic [CW-1:0] WIN_START = CW'(TICKS_PER_SEC - UIP_TICKS);

    logic [CW-1:0] cnt;
    logic          was_held;
    logic          held;
    logic          running;

    assign held    = dv_held(dv);
    assign running = dv_running(dv);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            was_held <= 1'b0;
        end else begin
            was_held <= held;
            if (held)
                cnt <= '0;
            else if (was_held)
                cnt <= HALF;
            else if (running && tick_en)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign uip       = running && !halt && !was_held && cnt >= WIN_START;
    assign sec_pulse = running && !halt && !was_held && tick_en && cnt == LAST;

    // R9
    half_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(held) |=> cnt == HALF);
    // R7
    pulse_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> uip);
    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (halt || held) |-> !uip && !sec_pulse);

endmodule

// File: rtl/rtc_irqstat.sv
module rtc_irqstat (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       soft_rst,
    input  rtc_regport_pkg::rtc_evt_t  ev,
    input  rtc_regport_pkg::rtc_evt_t  en,
    input  logic                       b_wr,
    input  rtc_regport_pkg::rtc_evt_t  b_en,
    input  logic                       c_rd,
    output logic [7:0]                 c_val,
    output logic                       irq
);
    import rtc_regport_pkg::*;

    rtc_evt_t flags, base, nflags, fresh, en_eff;
    logic     irqf, base_irqf, irqf_n;

    always_comb begin
        base      = c_rd ? rtc_evt_t'(3'b000) : flags;
        base_irqf = c_rd ? 1'b0 : irqf;
        nflags    = base | ev;
        fresh     = ev & ~base;
        en_eff    = b_wr ? b_en : en;
        if (b_wr)
            irqf_n = |(en_eff & nflags);
        else
            irqf_n = base_irqf | (|(fresh & en_eff));
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            flags <= '0;
            irqf  <= 1'b0;
        end else begin
            flags <= nflags;
            irqf  <= irqf_n;
        end
    end

    assign c_val = {irqf, flags, 4'b0000};
    assign irq   = irqf;

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        c_rd && ev == '0 && !b_wr |=> c_val == 8'h00 && !irq);
    // R11
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !c_rd && !b_wr && !soft_rst |=> irq);
    // R5
    irq_has_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> c_val[6:4] != 3'b000);
    // R6
    b_write_fire_chk: assert property (@(posedge clk) disable iff (rst)
        b_wr && !soft_rst && (b_en & flags) != '0 |=> irq);

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       bus_addr,
    input  logic       bus_we,
    input  logic       bus_re,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_en,
    input  logic       ev_periodic,
    input  logic       ev_alarm,
    output logic       sec_pulse,
    output logic       irq
);
    import rtc_regport_pkg::*;

    localparam int IW    = 7;
    localparam int DEPTH = 1 << IW;

    logic [IW-1:0] idx;
    logic [6:0]    reg_a;
    logic [7:0]    reg_b;
    logic [7:0]    c_val, mem_q;
    logic          wr_idx, wr_dat, c_rd, b_wr, uip, upd;
    rtc_evt_t      ev, en, b_en;

    assign wr_idx = bus_we && !bus_addr;
    assign wr_dat = bus_we && bus_addr;
    assign b_wr   = wr_dat && idx == IDX_B;
    assign c_rd   = bus_re && bus_addr && idx == IDX_C;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            reg_a <= A_RST;
            reg_b <= B_RST;
        end else begin
            if (wr_idx)
                idx <= bus_wdata[IW-1:0];
            if (wr_dat && idx == IDX_A)
                reg_a <= bus_wdata[6:0];
            if (soft_rst)
                reg_b <= reg_b & ~B_SOFT_CLR;
            else if (b_wr)
                reg_b <= bus_wdata;
        end
    end

    rtc_divchain #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .dv        (reg_a[6:4]),
        .halt      (reg_b[7]),
        .uip       (uip),
        .sec_pulse (upd)
    );

    assign sec_pulse = upd;
    assign ev   = '{pf: ev_periodic, af: ev_alarm, uf: upd};
    assign en   = rtc_evt_t'(reg_b[6:4]);
    assign b_en = rtc_evt_t'(bus_wdata[6:4]);

    rtc_irqstat u_irq (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .ev       (ev),
        .en       (en),
        .b_wr     (b_wr),
        .b_en     (b_en),
        .c_rd     (c_rd),
        .c_val    (c_val),
        .irq      (irq)
    );

    rtc_nvram #(.DEPTH(DEPTH), .AW(IW)) u_mem (
        .clk   (clk),
        .we    (wr_dat && !is_ctrl_idx(idx)),
        .waddr (idx),
        .wdata (bus_wdata),
        .raddr (idx),
        .rdata (mem_q)
    );

    always_comb begin
        if (!bus_addr)
            bus_rdata = 8'hFF;
        else begin
            unique case (idx)
                IDX_A:   bus_rdata = {uip, reg_a};
                IDX_B:   bus_rdata = reg_b;
                IDX_C:   bus_rdata = c_val;
                IDX_D:   bus_rdata = D_VAL;
                default: bus_rdata = mem_q;
            endcase
        end
    end

    // R1
    index_latch_chk: assert property (@(posedge clk) disable iff (rst)
        wr_idx |=> idx == $past(bus_wdata[IW-1:0]));
    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (reg_b & B_SOFT_CLR) == 8'h00 && !irq);

endmodule

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 64;
    localparam int UIPT       = 8;
    localparam int WDOG       = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       ev_periodic = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       sec_pulse;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regport #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .ev_periodic(ev_periodic), .ev_alarm(ev_alarm),
        .sec_pulse(sec_pulse), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] i, input logic [7:0] d);
        wr(1'b0, i);
        wr(1'b1, d);
    endtask

    task automatic rreg(input logic [7:0] i, output logic [7:0] d);
        wr(1'b0, i);
        rd(1'b1, d);
    endtask

    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            #1 if (sec_pulse) pulses++;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic event_pulse(input logic pf, input logic af);
        @(negedge clk);
        ev_periodic = pf; ev_alarm = af;
        @(negedge clk);
        ev_periodic = 1'b0; ev_alarm = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        rreg(8'h0A, d); chk("R2 reg A", d, 8'h26);
        rreg(8'h0B, d); chk("R2 reg B", d, 8'h02);
        rreg(8'h0C, d); chk("R2 reg C", d, 8'h00);
        rreg(8'h0D, d); chk("R2 reg D", d, 8'h80);
        chk("R2 irq", irq, 0);
    endtask

    task automatic t_uip_window();
        logic [7:0] d;
        int p;
        ticks(TPS - UIPT - 1, p);
        rreg(8'h0A, d); chk("R7 uip before window", d, 8'h26);
        ticks(1, p);
        rreg(8'h0A, d); chk("R7 uip in window", d, 8'hA6);
        ticks(UIPT - 1, p); chk("R7 no early pulse", p, 0);
        ticks(1, p); chk("R7 pulse on last tick", p, 1);
        rreg(8'h0C, d); chk("R7 update flag", d, 8'h10);
        rreg(8'h0A, d); chk("R7 uip after update", d, 8'h26);
    endtask

    task automatic t_divider_hold();
        logic [7:0] d;
        int p;
        wreg(8'h0A, 8'h66);
        rreg(8'h0A, d); chk("R8 uip low while held", d, 8'h66);
        ticks(100, p); chk("R8 no pulse while held", p, 0);
        rreg(8'h0C, d); chk("R8 no update flag while held", d, 8'h00);
        wreg(8'h0A, 8'h26);
        @(negedge clk);
        ticks(TPS/2 - UIPT, p);
        rreg(8'h0A, d); chk("R9 uip after half second", d, 8'hA6);
        ticks(UIPT - 1, p); chk("R9 no pulse before half second", p, 0);
        ticks(1, p); chk("R9 pulse at half second", p, 1);
        rreg(8'h0C, d); chk("R9 update flag", d, 8'h10);
    endtask

    task automatic t_set_mode();
        logic [7:0] d;
        int p;
        wreg(8'h0B, 8'h82);
        ticks(TPS - 4, p);
        rreg(8'h0A, d); chk("R8 uip low in set mode", d, 8'h26);
        ticks(4, p); chk("R8 no pulse in set mode", p, 0);
        rreg(8'h0C, d); chk("R8 no flag in set mode", d, 8'h00);
        wreg(8'h0B, 8'h02);
    endtask

    task automatic t_update_irq();
        logic [7:0] d;
        int p;
        wreg(8'h0B, 8'h12);
        ticks(TPS, p); chk("R5 pulse", p, 1);
        chk("R5 irq on enabled update", irq, 1);
        repeat (5) @(negedge clk);
        chk("R11 irq holds", irq, 1);
        rreg(8'h0C, d); chk("R4 read value", d, 8'h90);
        chk("R4 irq cleared", irq, 0);
        rreg(8'h0C, d); chk("R4 C cleared", d, 8'h00);
    endtask

    task automatic t_enable_on_write();
        logic [7:0] d;
        event_pulse(1'b0, 1'b1);
        chk("R5 masked flag no irq", irq, 0);
        wreg(8'h0B, 8'h32);
        chk("R6 enable pending fires", irq, 1);
        rreg(8'h0C, d); chk("R6 C after fire", d, 8'hA0);
        event_pulse(1'b0, 1'b1);
        chk("R5 alarm irq", irq, 1);
        wreg(8'h0B, 8'h12);
        chk("R6 disable clears irq", irq, 0);
        rreg(8'h0C, d); chk("R6 flag kept, IRQF cleared", d, 8'h20);
    endtask

    task automatic t_read_race();
        logic [7:0] d;
        wreg(8'h0B, 8'h42);
        wr(1'b0, 8'h0C);
        @(negedge clk);
        bus_addr = 1'b1; bus_re = 1'b1; ev_periodic = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; ev_periodic = 1'b0;
        chk("R4 read before event", d, 8'h00);
        chk("R4 event kept irq", irq, 1);
        rd(1'b1, d); chk("R4 event kept flag", d, 8'hC0);
    endtask

    task automatic t_read_only();
        logic [7:0] d;
        wreg(8'h0C, 8'hFF);
        rreg(8'h0C, d); chk("R3 C write ignored", d, 8'h00);
        chk("R3 irq untouched", irq, 0);
        wreg(8'h0D, 8'h00);
        rreg(8'h0D, d); chk("R3 D write ignored", d, 8'h80);
        wreg(8'h0A, 8'hA6);
        rreg(8'h0A, d); chk("R3 uip not writable", d, 8'h26);
    endtask

    task automatic t_storage();
        logic [7:0] d;
        wreg(8'h20, 8'h5A);
        wreg(8'h7F, 8'h33);
        rreg(8'h20, d); chk("R1 store 0x20", d, 8'h5A);
        rreg(8'h7F, d); chk("R1 store 0x7F", d, 8'h33);
        wreg(8'h8E, 8'h77);
        rreg(8'h0E, d); chk("R1 index bit7 dropped", d, 8'h77);
        rd(1'b0, d); chk("R1 even read", d, 8'hFF);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        wreg(8'h0B, 8'h7E);
        event_pulse(1'b0, 1'b1);
        chk("R10 irq before soft reset", irq, 1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R10 irq low", irq, 0);
        rreg(8'h0B, d); chk("R10 B enables cleared", d, 8'h16);
        rreg(8'h0C, d); chk("R10 C cleared", d, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_uip_window();
        t_divider_hold();
        t_set_mode();
        t_update_irq();
        t_enable_on_write();
        t_read_race();
        t_read_only();
        t_storage();
        t_soft_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule